// File: doc/BRIEF.md
# Low-Power Wake-Up Detector

This block watches two inputs while the transceiver is in a low-power mode. One is a local wake input pin. The other is the received bus level. It raises a wake-up flag when a qualified wake condition appears.

- A local wake is any change of the wake pin's level, rising or falling, that stays stable for `TWAKE_CYC` clock cycles. Once a change qualifies, the new level becomes the reference for the next change.
- A remote wake is the bus held dominant for `TBUS_CYC` cycles.

A second flag records that a local request was accepted. Software can then tell the two wake causes apart once the node is back in normal operation. Both the pin and the bus level pass through two-flop synchronisers.

Setting the wake-up flag depends on the operating mode and on the state of the supply-undervoltage flag's waiting window. Clearing the two flags is driven by the surrounding mode controller through mode-entry and mode-exit strobes. A set wake-up flag is also driven, active low, onto two indication outputs: one toward the receive-data pin and one toward the error pin. This happens only while the mode is a low-power one.

Top module: `wake_detect`

## Requirements
- R1: A level change on `wake_pin`, in either direction, held for `TWAKE_CYC` cycles in a low-power mode sets `wake_flag`. After the change is applied, the flag is still low after `TWAKE_CYC+1` rising edges and is high after `TWAKE_CYC+4` rising edges.
- R2: A pulse on `wake_pin` shorter than `TWAKE_CYC` cycles sets no flag. After a change qualifies, the reference level follows it, so a later return to the old level is itself a qualifying change.
- R3: `bus_dom` held at 1 (dominant) for `TBUS_CYC` cycles in a low-power mode sets `wake_flag`. The flag is still low after `TBUS_CYC+1` rising edges and is high after `TBUS_CYC+4` rising edges.
- R4: A dominant run shorter than `TBUS_CYC` cycles sets no flag.
- R5: The `mode` encoding is 0 normal, 1 listen-only, 2 standby, 3 go-to-sleep and 4 sleep. `wake_flag` may set only while `mode` is 2, 3 or 4.
- R6: While `uvnom_wait` is 1, no request sets `wake_flag`.
- R7: `wake_flag` clears one edge after an `enter_normal` pulse, or after the first cycle in which `uvnom_flag` is seen high following a low cycle. It also clears on reset. A clear takes priority over a set in the same cycle.
- R8: `wake_src` sets when a local request is accepted into `wake_flag`, but only while `pwon_flag` is 0. A remote request never sets it.
- R9: `wake_src` clears one edge after a `leave_normal` pulse, or on reset. Otherwise it holds, including across `enter_normal`.
- R10: `rxd_wake_n` and `err_wake_n` are low exactly when the wake-up flag is set and the mode sampled at the same edge is 2, 3 or 4. Otherwise they are high. They change at the same edge as `wake_flag`.
- R11: After a synchronous reset, `wake_flag` and `wake_src` are 0 and both indication outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also serves as power-on clear |
| wake_pin | input | 1 | Local wake input, asynchronous |
| bus_dom | input | 1 | Received bus level, 1 = dominant, asynchronous |
| mode | input | 3 | Current operating mode (encoding in R5) |
| pwon_flag | input | 1 | Power-on flag from the mode controller |
| uvnom_flag | input | 1 | Supply undervoltage flag |
| uvnom_wait | input | 1 | High during the undervoltage waiting window |
| enter_normal | input | 1 | One-cycle strobe on entering normal mode |
| leave_normal | input | 1 | One-cycle strobe on leaving normal mode |
| wake_flag | output | 1 | Wake-up flag |
| wake_src | output | 1 | Set when the wake was local |
| rxd_wake_n | output | 1 | Active-low wake indication toward the receive-data pin |
| err_wake_n | output | 1 | Active-low wake indication toward the error pin |

## Verification
The assertions assume the following of the inputs:
- `mode`, `pwon_flag`, `uvnom_flag`, `uvnom_wait` and the two strobes are synchronous to `clk`.
- `enter_normal` arrives together with `mode` 0, and `leave_normal` with a non-normal mode.

The stimulus drives every input half a cycle away from the rising edge. Each strobe is a single cycle, issued with its matching mode. Only `wake_pin` and `bus_dom` are treated as asynchronous, and only they are given arbitrary pulse lengths.

// File: rtl/wkd_pkg.sv
package wkd_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_LISTEN  = 3'd1,
    MODE_STANDBY = 3'd2,
    MODE_GOSLEEP = 3'd3,
    MODE_SLEEP   = 3'd4
  } op_mode_e;

  // True for the modes in which a wake request may be accepted
  function automatic logic is_low_power(input logic [2:0] m);
    return (m == MODE_STANDBY) || (m == MODE_GOSLEEP) || (m == MODE_SLEEP);
  endfunction

endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wkd_level_change.sv
// Qualifies a change of a synchronised level against a stored reference.
// One-cycle request pulse when the new level has been stable for CYC cycles.
module wkd_level_change #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic req
);

  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic          ref_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      req <= 1'b0;
      if (lvl == ref_q) begin
        cnt_q <= '0;                 // glitch ended: restart qualification
      end else if (cnt_q == LAST) begin
        ref_q <= lvl;                // new stable level becomes the reference
        cnt_q <= '0;
        req   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wkd_dom_timer.sv
// Fires one request pulse per dominant run lasting CYC cycles.
module wkd_dom_timer #(
  parameter int CYC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic dom,
  output logic req
);

  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!dom) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (cnt_q == LAST) begin
          done_q <= 1'b1;
          req    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wkd_pkg::*;
#(
  parameter int TWAKE_CYC   = 8,
  parameter int TBUS_CYC    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake_pin,
  input  logic       bus_dom,
  input  logic [2:0] mode,
  input  logic       pwon_flag,
  input  logic       uvnom_flag,
  input  logic       uvnom_wait,
  input  logic       enter_normal,
  input  logic       leave_normal,
  output logic       wake_flag,
  output logic       wake_src,
  output logic       rxd_wake_n,
  output logic       err_wake_n
);

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] async_in, sync_out;
  logic             wake_s, dom_s;
  logic             local_req, remote_req;

  assign async_in = {bus_dom, wake_pin};

  wkd_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (sync_out)
  );

  assign wake_s = sync_out[0];
  assign dom_s  = sync_out[1];

  wkd_level_change #(.CYC(TWAKE_CYC)) i_local (
    .clk (clk),
    .rst (rst),
    .lvl (wake_s),
    .req (local_req)
  );

  wkd_dom_timer #(.CYC(TBUS_CYC)) i_remote (
    .clk (clk),
    .rst (rst),
    .dom (dom_s),
    .req (remote_req)
  );

  logic wake_q, src_q, uv_prev_q, rxd_n_q, err_n_q;
  logic low_pwr, set_ok, uv_rise, clr_wake, accept_local, wake_d, src_d;

  always_comb begin
    low_pwr      = is_low_power(mode);
    set_ok       = low_pwr && !uvnom_wait;
    uv_rise      = uvnom_flag && !uv_prev_q;
    clr_wake     = enter_normal || uv_rise;
    accept_local = set_ok && local_req && !clr_wake;

    wake_d = wake_q;
    if (clr_wake)                               wake_d = 1'b0;
    else if (set_ok && (local_req || remote_req)) wake_d = 1'b1;

    src_d = src_q;
    if (leave_normal)                   src_d = 1'b0;
    else if (accept_local && !pwon_flag) src_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q    <= 1'b0;
      src_q     <= 1'b0;
      uv_prev_q <= 1'b0;
      rxd_n_q   <= 1'b1;
      err_n_q   <= 1'b1;
    end else begin
      wake_q    <= wake_d;
      src_q     <= src_d;
      uv_prev_q <= uvnom_flag;
      rxd_n_q   <= !(wake_d && low_pwr);
      err_n_q   <= !(wake_d && low_pwr);
    end
  end

  assign wake_flag  = wake_q;
  assign wake_src   = src_q;
  assign rxd_wake_n = rxd_n_q;
  assign err_wake_n = err_n_q;

endmodule

// File: rtl/wkd_checker.sv
module wkd_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       pwon_flag,
  input logic       uvnom_flag,
  input logic       uvnom_wait,
  input logic       enter_normal,
  input logic       leave_normal,
  input logic       wake_flag,
  input logic       wake_src,
  input logic       rxd_wake_n,
  input logic       err_wake_n
);

  AST_SET_IN_LOW_POWER: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> ($past(mode) inside {3'd2, 3'd3, 3'd4})); // R5

  AST_SET_NOT_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> !$past(uvnom_wait)); // R6

  AST_CLR_ON_NORMAL: assert property (@(posedge clk) disable iff (rst)
    enter_normal |=> !wake_flag); // R7

  AST_CLR_ON_UV: assert property (@(posedge clk) disable iff (rst)
    $rose(uvnom_flag) |=> !wake_flag); // R7

  AST_SRC_AFTER_PWON: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_src) |-> !$past(pwon_flag)); // R8

  AST_SRC_WITH_WAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_src) |-> wake_flag); // R8

  AST_SRC_CLR_LEAVE: assert property (@(posedge clk) disable iff (rst)
    leave_normal |=> !wake_src); // R9

  AST_IND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !rxd_wake_n |-> wake_flag && ($past(mode) inside {3'd2, 3'd3, 3'd4})); // R10

  AST_IND_PINS_AGREE: assert property (@(posedge clk) disable iff (rst)
    rxd_wake_n == err_wake_n); // R10

endmodule

bind wake_detect wkd_checker i_wkd_checker (.*);

// File: tb/test_wake_detect.sv
module test_wake_detect;

  localparam int TW = 8;
  localparam int TB = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_pin = 1'b0, bus_dom = 1'b0;
  logic [2:0] mode = 3'd0;
  logic pwon_flag = 1'b0, uvnom_flag = 1'b0, uvnom_wait = 1'b0;
  logic enter_normal = 1'b0, leave_normal = 1'b0;
  logic wake_flag, wake_src, rxd_wake_n, err_wake_n;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  wake_detect #(.TWAKE_CYC(TW), .TBUS_CYC(TB)) i_wake_detect (
    .clk(clk), .rst(rst), .wake_pin(wake_pin), .bus_dom(bus_dom), .mode(mode),
    .pwon_flag(pwon_flag), .uvnom_flag(uvnom_flag), .uvnom_wait(uvnom_wait),
    .enter_normal(enter_normal), .leave_normal(leave_normal),
    .wake_flag(wake_flag), .wake_src(wake_src),
    .rxd_wake_n(rxd_wake_n), .err_wake_n(err_wake_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wake_pin = 1'b0; bus_dom = 1'b0; mode = 3'd0;
    pwon_flag = 1'b0; uvnom_flag = 1'b0; uvnom_wait = 1'b0;
    enter_normal = 1'b0; leave_normal = 1'b0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic pulse_enter_normal();
    mode = 3'd0; enter_normal = 1'b1; cyc(1); enter_normal = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11", "wake_flag", wake_flag, 1'b0);
    chk("R11", "wake_src", wake_src, 1'b0);
    chk("R11", "rxd_wake_n", rxd_wake_n, 1'b1);
    chk("R11", "err_wake_n", err_wake_n, 1'b1);
  endtask

  task automatic t_local_rise();
    do_reset();
    mode = 3'd2;
    wake_pin = 1'b1;
    cyc(TW + 1);
    chk("R1", "flag before qualification", wake_flag, 1'b0);
    cyc(3);
    chk("R1", "flag after rising change", wake_flag, 1'b1);
    chk("R8", "source after local wake", wake_src, 1'b1);
    chk("R10", "rxd_wake_n in standby", rxd_wake_n, 1'b0);
    chk("R10", "err_wake_n in standby", err_wake_n, 1'b0);
  endtask

  task automatic t_local_fall_and_mode_gate();
    do_reset();
    wake_pin = 1'b1;            // normal mode: change qualifies but is ignored
    cyc(TW + 6);
    chk("R5", "flag after change in normal mode", wake_flag, 1'b0);
    chk("R10", "rxd_wake_n in normal mode", rxd_wake_n, 1'b1);
    mode = 3'd4;
    wake_pin = 1'b0;
    cyc(TW + 1);
    chk("R1", "flag before falling qualified", wake_flag, 1'b0);
    cyc(3);
    chk("R1", "flag after falling change in sleep", wake_flag, 1'b1);
  endtask

  task automatic t_glitch_and_reference();
    do_reset();
    mode = 3'd2;
    wake_pin = 1'b1; cyc(TW - 2); wake_pin = 1'b0;
    cyc(3 * TW);
    chk("R2", "flag after short glitch", wake_flag, 1'b0);
    wake_pin = 1'b1; cyc(TW + 4);
    chk("R2", "flag after long high", wake_flag, 1'b1);
    pulse_enter_normal();
    chk("R7", "flag after enter_normal", wake_flag, 1'b0);
    mode = 3'd2;
    wake_pin = 1'b0; cyc(TW + 4);
    chk("R2", "return to low is a new change", wake_flag, 1'b1);
  endtask

  task automatic t_remote();
    do_reset();
    mode = 3'd3;
    bus_dom = 1'b1;
    cyc(TB + 1);
    chk("R3", "flag before dominant qualified", wake_flag, 1'b0);
    cyc(3);
    chk("R3", "flag after long dominant", wake_flag, 1'b1);
    chk("R8", "source after remote wake", wake_src, 1'b0);
    bus_dom = 1'b0;
  endtask

  task automatic t_remote_short();
    do_reset();
    mode = 3'd2;
    bus_dom = 1'b1; cyc(TB - 1); bus_dom = 1'b0;
    cyc(2 * TB);
    chk("R4", "flag after short dominant", wake_flag, 1'b0);
  endtask

  task automatic t_uv_wait_block();
    do_reset();
    mode = 3'd2; uvnom_wait = 1'b1;
    wake_pin = 1'b1; cyc(TW + 6);
    chk("R6", "flag during waiting window", wake_flag, 1'b0);
    uvnom_wait = 1'b0;
    bus_dom = 1'b1; cyc(TB + 4); bus_dom = 1'b0;
    chk("R6", "flag after window closed", wake_flag, 1'b1);
  endtask

  task automatic t_uv_clear();
    do_reset();
    mode = 3'd4;
    bus_dom = 1'b1; cyc(TB + 4); bus_dom = 1'b0;
    chk("R3", "flag set before uv", wake_flag, 1'b1);
    uvnom_flag = 1'b1; cyc(1);
    chk("R7", "flag after uvnom rise", wake_flag, 1'b0);
    chk("R10", "rxd_wake_n after uv clear", rxd_wake_n, 1'b1);
    uvnom_flag = 1'b0;
  endtask

  task automatic t_source_pwon_and_leave();
    do_reset();
    mode = 3'd2; pwon_flag = 1'b1;
    wake_pin = 1'b1; cyc(TW + 4);
    chk("R1", "flag with pwon set", wake_flag, 1'b1);
    chk("R8", "source blocked by pwon", wake_src, 1'b0);
    pulse_enter_normal();
    pwon_flag = 1'b0;
    mode = 3'd2; leave_normal = 1'b1; cyc(1); leave_normal = 1'b0;
    wake_pin = 1'b0; cyc(TW + 4);
    chk("R8", "source after pwon cleared", wake_src, 1'b1);
    pulse_enter_normal();
    chk("R9", "source holds on enter_normal", wake_src, 1'b1);
    mode = 3'd2; leave_normal = 1'b1; cyc(1); leave_normal = 1'b0;
    chk("R9", "source after leave_normal", wake_src, 1'b0);
  endtask

  task automatic t_indicator_mode();
    do_reset();
    mode = 3'd2;
    wake_pin = 1'b1; cyc(TW + 4);
    chk("R10", "err_wake_n low in standby", err_wake_n, 1'b0);
    mode = 3'd1; cyc(1);
    chk("R10", "flag kept in listen-only", wake_flag, 1'b1);
    chk("R10", "rxd_wake_n high in listen-only", rxd_wake_n, 1'b1);
    chk("R10", "err_wake_n high in listen-only", err_wake_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_local_rise();
    t_local_fall_and_mode_gate();
    t_glitch_and_reference();
    t_remote();
    t_remote_short();
    t_uv_wait_block();
    t_uv_clear();
    t_source_pwon_and_leave();
    t_indicator_mode();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule